// File: doc/BRIEF.md
# Page-Mode Burst ROM Access Controller

This block sits between a host request port and an external asynchronous ROM that offers fast page-mode reads. The host hands over one request at a time: a byte address, an access size, a read/write flag and, for writes, the data. The controller then drives the memory strobes and the address bus, waits the configured number of cycles for each beat, and hands every captured read beat back with a valid pulse. A done pulse marks the last beat.

A read wider than the data bus is split into beats. Inside a burst the read strobe and chip select stay low, and each later beat is made only by moving the address, which changes on the falling clock edge. The first beat of a burst uses a 4-bit wait count, honours the external wait input and carries the one-cycle bus-start strobe. Later beats use a 2-bit wait count and ignore the wait input. A burst-length setting can cut a long read into several shorter bursts. Single reads and every write beat use plain one-access-at-a-time timing.

Top module: `pagerom_ctrl`

## Requirements
- R1: After reset, bus_cs_n, bus_rd_n, bus_we_n and bus_bs_n are high, req_ready is high, and rsp_beat_valid and rsp_done are low.
- R2: The first beat of every burst and every normal access lasts cfg_first_wait+1 cycles, counted from the edge that starts it. If bus_wait is high at the rising edge that would end the beat, the beat is extended by one cycle for each such edge. Read data is captured at the rising edge that ends the beat, and rsp_beat_valid pulses high for the following cycle with that data on rsp_data.
- R3: Each second and later beat of a burst lasts cfg_burst_wait+1 cycles, whatever the level of bus_wait.
- R4: Within a read burst, bus_cs_n and bus_rd_n stay low without a break from the first beat to the last. bus_bs_n is low only in the first clock cycle of each burst or normal access.
- R5: Beat k of an access addresses the aligned base plus k times BUS_BYTES. The aligned base is the request address with the low log2(size in bytes) bits cleared. The first beat of a burst is on bus_addr from the rising edge that starts it. A later beat's address appears at the falling edge after the previous beat's capture edge, and the old address is still present just after that capture edge.
- R6: req_size codes 0, 1, 2 and 3 mean 1, 2, 4 and 16 bytes. The beat count is the size divided by BUS_BYTES, with a minimum of one, so an access no wider than the bus is a single normal access.
- R7: cfg_burst_len 0 makes a read one burst of all its beats. Settings 1, 2 and 3 cap a burst at 8, 4 and 2 beats. Between two bursts of one access, bus_cs_n and bus_rd_n are high for exactly one cycle.
- R8: A write never forms a burst. Every beat is a normal access with bus_we_n low (bus_rd_n high) and bus_bs_n low in its first cycle. Byte lane k of req_wdata (bits 8k+7 down to 8k, for a bus of one byte) is on bus_dout during beat k. No rsp_beat_valid is produced.
- R9: rsp_done pulses for exactly the cycle after the last beat's capture edge. In that cycle bus_cs_n is high and req_ready is low. req_ready rises in the cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle, request taken at this edge |
| req_addr | input | ADDR_W | Request byte address |
| req_size | input | 2 | Access size code (1, 2, 4, 16 bytes) |
| req_write | input | 1 | 1 for a write access |
| req_wdata | input | 128 | Write data, byte lane k for beat k |
| cfg_first_wait | input | 4 | Wait cycles for a first beat |
| cfg_burst_wait | input | 2 | Wait cycles for each later beat |
| cfg_burst_len | input | 2 | Burst length cap setting |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_we_n | output | 1 | Write strobe, active low |
| bus_bs_n | output | 1 | Bus-start strobe, active low |
| bus_addr | output | ADDR_W | Memory address |
| bus_dout | output | 8*BUS_BYTES | Write data to memory |
| bus_din | input | 8*BUS_BYTES | Read data from memory |
| bus_wait | input | 1 | External wait request, active high |
| rsp_beat_valid | output | 1 | Captured read beat valid |
| rsp_data | output | 8*BUS_BYTES | Captured read beat |
| rsp_done | output | 1 | Last beat of the access finished |

## Verification
The bench holds bus_wait high through the later beats of every burst. A design that honoured it there would stretch those beats, and the per-cycle timing checks would catch it. It also holds the wait input high at the end of first beats, so a first beat that ignored the wait would capture early and return the wrong ROM byte. The address is sampled both just after the capture edge and just after the following falling edge, so an address stepped on the rising edge, or stepped late, fails R5. Split bursts, unaligned requests and multi-beat writes are there to catch a design that keeps the read strobe low across a group boundary, forgets to align the base, or lets writes run as a page-mode burst.

// File: rtl/pagerom_pkg.sv
package pagerom_pkg;

   localparam int MAX_BYTES = 16;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_FIRST = 2'd1,
      ST_NEXT  = 2'd2,
      ST_GAP   = 2'd3
   } pr_state_e;

   // Size code to byte count
   function automatic int size_bytes(input logic [1:0] code);
      case (code)
         2'd0:    return 1;
         2'd1:    return 2;
         2'd2:    return 4;
         default: return MAX_BYTES;
      endcase
   endfunction

   // Burst length cap for a read of nb beats
   function automatic int group_cap(input logic [1:0] sel, input int nb);
      case (sel)
         2'd0:    return nb;
         2'd1:    return 8;
         2'd2:    return 4;
         default: return 2;
      endcase
   endfunction

endpackage

// File: rtl/pagerom_beat_plan.sv
module pagerom_beat_plan
   import pagerom_pkg::*;
#(
   parameter int ADDR_W    = 24,
   parameter int BUS_BYTES = 1,
   parameter int BEAT_W    = 5
)(
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [1:0]        size_i,
   input  logic              write_i,
   input  logic [1:0]        blen_i,
   output logic [ADDR_W-1:0] base_o,
   output logic [BEAT_W-1:0] nbeats_o,
   output logic [BEAT_W-1:0] glen_o
);
   localparam int BB_LG = $clog2(BUS_BYTES);

   int bytes;
   int nb;
   int cap;

   always_comb begin
      bytes    = size_bytes(size_i);
      nb       = (bytes > BUS_BYTES) ? (bytes >> BB_LG) : 1;
      cap      = group_cap(blen_i, nb);
      nbeats_o = BEAT_W'(nb);
      // writes always run beat by beat with normal timing
      glen_o   = write_i ? BEAT_W'(1) : BEAT_W'((cap < nb) ? cap : nb);
      base_o   = addr_i & ~(ADDR_W'(bytes - 1));
   end

endmodule

// File: rtl/pagerom_wait_timer.sv
module pagerom_wait_timer #(
   parameter int CNT_W = 4
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] val_i,
   output logic             zero_o
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt_q <= '0;
      else if (load_i)           cnt_q <= val_i;
      else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
   end

   assign zero_o = (cnt_q == '0);

   // R2: an expired count stays expired until the next beat reloads it
   a_r2_zero_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (zero_o && !load_i) |=> zero_o);

   // R2: a nonzero load takes at least one more cycle
   a_r2_load_counts: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && val_i != '0) |=> !zero_o);

endmodule

// File: rtl/pagerom_addr_gen.sv
module pagerom_addr_gen #(
   parameter int ADDR_W    = 24,
   parameter int BUS_BYTES = 1,
   parameter int BEAT_W    = 5
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] base_i,
   input  logic [BEAT_W-1:0] idx_i,
   input  logic              direct_i,
   output logic [ADDR_W-1:0] addr_o
);
   localparam int BB_LG = $clog2(BUS_BYTES);

   logic [ADDR_W-1:0] beat_addr;
   logic [ADDR_W-1:0] fall_q;

   generate
      if (BB_LG == 0) begin : g_byte_bus
         assign beat_addr = base_i + ADDR_W'(idx_i);
      end else begin : g_wide_bus
         assign beat_addr = base_i + (ADDR_W'(idx_i) << BB_LG);
      end
   endgenerate

   // later beats step on the falling edge
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) fall_q <= '0;
      else        fall_q <= beat_addr;
   end

   assign addr_o = direct_i ? beat_addr : fall_q;

   // R5: during a later beat the stepped address has settled before each rising edge
   a_r5_settled_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
      (!direct_i && $past(!direct_i)) |-> (addr_o == beat_addr));

endmodule

// File: rtl/pagerom_ctrl.sv
module pagerom_ctrl
   import pagerom_pkg::*;
#(
   parameter int ADDR_W    = 24,
   parameter int BUS_BYTES = 1
)(
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     req_valid,
   output logic                     req_ready,
   input  logic [ADDR_W-1:0]        req_addr,
   input  logic [1:0]               req_size,
   input  logic                     req_write,
   input  logic [MAX_BYTES*8-1:0]   req_wdata,
   input  logic [3:0]               cfg_first_wait,
   input  logic [1:0]               cfg_burst_wait,
   input  logic [1:0]               cfg_burst_len,
   output logic                     bus_cs_n,
   output logic                     bus_rd_n,
   output logic                     bus_we_n,
   output logic                     bus_bs_n,
   output logic [ADDR_W-1:0]        bus_addr,
   output logic [BUS_BYTES*8-1:0]   bus_dout,
   input  logic [BUS_BYTES*8-1:0]   bus_din,
   input  logic                     bus_wait,
   output logic                     rsp_beat_valid,
   output logic [BUS_BYTES*8-1:0]   rsp_data,
   output logic                     rsp_done
);
   localparam int BUS_W   = BUS_BYTES * 8;
   localparam int WDATA_W = MAX_BYTES * 8;
   localparam int BEAT_W  = $clog2(MAX_BYTES) + 1;

   generate
      if (!(BUS_BYTES == 1 || BUS_BYTES == 2 || BUS_BYTES == 4)) begin : g_bad_bus
         $error("pagerom_ctrl: BUS_BYTES must be 1, 2 or 4");
      end
      if (ADDR_W < 8) begin : g_bad_addr
         $error("pagerom_ctrl: ADDR_W must be at least 8");
      end
   endgenerate

   pr_state_e          st_q, st_d;
   logic [ADDR_W-1:0]  base_q;
   logic               wr_q;
   logic [WDATA_W-1:0] wdata_q;
   logic [BEAT_W-1:0]  nbeats_q, glen_q, idx_q, gidx_q;
   logic [3:0]         fw_q;
   logic [1:0]         bw_q;
   logic               first_cyc_q, fin_q;

   logic               tmr_zero, tmr_load;
   logic [3:0]         tmr_val;
   logic [ADDR_W-1:0]  plan_base;
   logic [BEAT_W-1:0]  plan_nbeats, plan_glen;

   logic accept, beat_end, last_all, last_grp, in_beat;

   pagerom_beat_plan #(
      .ADDR_W(ADDR_W), .BUS_BYTES(BUS_BYTES), .BEAT_W(BEAT_W)
   ) i_plan (
      .addr_i  (req_addr),
      .size_i  (req_size),
      .write_i (req_write),
      .blen_i  (cfg_burst_len),
      .base_o  (plan_base),
      .nbeats_o(plan_nbeats),
      .glen_o  (plan_glen)
   );

   pagerom_wait_timer #(.CNT_W(4)) i_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .load_i(tmr_load),
      .val_i (tmr_val),
      .zero_o(tmr_zero)
   );

   pagerom_addr_gen #(
      .ADDR_W(ADDR_W), .BUS_BYTES(BUS_BYTES), .BEAT_W(BEAT_W)
   ) i_addr (
      .clk     (clk),
      .rst_n   (rst_n),
      .base_i  (base_q),
      .idx_i   (idx_q),
      .direct_i(st_q != ST_NEXT),
      .addr_o  (bus_addr)
   );

   assign accept   = (st_q == ST_IDLE) && req_valid;
   assign beat_end = ((st_q == ST_FIRST) && tmr_zero && !bus_wait) ||
                     ((st_q == ST_NEXT)  && tmr_zero);
   assign last_all = ((idx_q + BEAT_W'(1)) == nbeats_q);
   assign last_grp = ((gidx_q + BEAT_W'(1)) == glen_q);
   assign in_beat  = (st_q == ST_FIRST) || (st_q == ST_NEXT);

   always_comb begin
      st_d     = st_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      case (st_q)
         ST_IDLE: begin
            if (accept) begin
               st_d     = ST_FIRST;
               tmr_load = 1'b1;
               tmr_val  = cfg_first_wait;
            end
         end
         ST_FIRST, ST_NEXT: begin
            if (beat_end) begin
               if (last_all || last_grp) begin
                  st_d = ST_GAP;
               end else begin
                  st_d     = ST_NEXT;
                  tmr_load = 1'b1;
                  tmr_val  = {2'b00, bw_q};
               end
            end
         end
         default: begin
            if (fin_q) begin
               st_d = ST_IDLE;
            end else begin
               st_d     = ST_FIRST;
               tmr_load = 1'b1;
               tmr_val  = fw_q;
            end
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q           <= ST_IDLE;
         base_q         <= '0;
         wr_q           <= 1'b0;
         wdata_q        <= '0;
         nbeats_q       <= '0;
         glen_q         <= '0;
         idx_q          <= '0;
         gidx_q         <= '0;
         fw_q           <= '0;
         bw_q           <= '0;
         first_cyc_q    <= 1'b0;
         fin_q          <= 1'b0;
         rsp_beat_valid <= 1'b0;
         rsp_data       <= '0;
         rsp_done       <= 1'b0;
      end else begin
         st_q           <= st_d;
         first_cyc_q    <= (st_d == ST_FIRST) && (st_q != ST_FIRST);
         rsp_beat_valid <= 1'b0;
         rsp_done       <= 1'b0;
         if (accept) begin
            base_q   <= plan_base;
            wr_q     <= req_write;
            wdata_q  <= req_wdata;
            nbeats_q <= plan_nbeats;
            glen_q   <= plan_glen;
            idx_q    <= '0;
            gidx_q   <= '0;
            fw_q     <= cfg_first_wait;
            bw_q     <= cfg_burst_wait;
            fin_q    <= 1'b0;
         end
         if (beat_end) begin
            idx_q          <= idx_q + BEAT_W'(1);
            gidx_q         <= last_grp ? '0 : gidx_q + BEAT_W'(1);
            rsp_beat_valid <= !wr_q;
            if (!wr_q) rsp_data <= bus_din;
            rsp_done       <= last_all;
            fin_q          <= last_all;
         end
      end
   end

   assign req_ready = (st_q == ST_IDLE);
   assign bus_cs_n  = !in_beat;
   assign bus_rd_n  = !(in_beat && !wr_q);
   assign bus_we_n  = !(in_beat && wr_q);
   assign bus_bs_n  = !((st_q == ST_FIRST) && first_cyc_q);
   assign bus_dout  = wdata_q[idx_q*BUS_W +: BUS_W];

   // R4: bus-start is a single-cycle strobe
   a_r4_bs_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_bs_n |=> bus_bs_n);

   // R4: a later beat is always preceded by a cycle with the read strobe low
   a_r4_rd_unbroken: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_NEXT) |-> $past(!bus_rd_n));

   // R2: a held wait at the end of a first beat delays the capture
   a_r2_wait_delays: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_FIRST && tmr_zero && bus_wait) |=> (st_q == ST_FIRST && !rsp_beat_valid));

   // R3: an expired later-beat count captures regardless of the wait input
   a_r3_wait_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_NEXT && tmr_zero) |=> rsp_beat_valid);

   // R8: writes never enter page-mode stepping, and strobes never overlap
   a_r8_write_no_page: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_we_n |-> (st_q != ST_NEXT));
   a_r8_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({~bus_rd_n, ~bus_we_n}));

   // R9: done is seen with the memory already deselected and the port busy
   a_r9_done_idle_bus: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |-> (bus_cs_n && !req_ready));

endmodule

// File: tb/test_pagerom_ctrl.sv
module test_pagerom_ctrl;
   localparam int ADDR_W = 24;
   localparam int BB     = 1;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         req_valid = 1'b0;
   logic         req_ready;
   logic [23:0]  req_addr = '0;
   logic [1:0]   req_size = '0;
   logic         req_write = 1'b0;
   logic [127:0] req_wdata = '0;
   logic [3:0]   cfg_first_wait = '0;
   logic [1:0]   cfg_burst_wait = '0;
   logic [1:0]   cfg_burst_len = '0;
   logic         bus_cs_n, bus_rd_n, bus_we_n, bus_bs_n;
   logic [23:0]  bus_addr;
   logic [7:0]   bus_dout;
   logic [7:0]   bus_din;
   logic         bus_wait = 1'b0;
   logic         rsp_beat_valid;
   logic [7:0]   rsp_data;
   logic         rsp_done;

   int n_checks = 0;
   int n_fails  = 0;
   bit finished = 1'b0;

   // 50 MHz: 20-unit period
   always #10 clk = ~clk;

   function automatic logic [7:0] rom_byte(input logic [23:0] a);
      return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h3C;
   endfunction

   assign bus_din = rom_byte(bus_addr);

   pagerom_ctrl #(.ADDR_W(ADDR_W), .BUS_BYTES(BB)) i_pagerom_ctrl (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_size(req_size), .req_write(req_write),
      .req_wdata(req_wdata),
      .cfg_first_wait(cfg_first_wait), .cfg_burst_wait(cfg_burst_wait),
      .cfg_burst_len(cfg_burst_len),
      .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n), .bus_we_n(bus_we_n),
      .bus_bs_n(bus_bs_n), .bus_addr(bus_addr), .bus_dout(bus_dout),
      .bus_din(bus_din), .bus_wait(bus_wait),
      .rsp_beat_valid(rsp_beat_valid), .rsp_data(rsp_data), .rsp_done(rsp_done)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic report();
      if (!finished) begin
         finished = 1'b1;
         $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
         $finish;
      end
   endtask

   function automatic int bytes_of(input logic [1:0] code);
      case (code)
         2'd0: return 1;
         2'd1: return 2;
         2'd2: return 4;
         default: return 16;
      endcase
   endfunction

   function automatic int burst_of(input logic [1:0] bl, input bit wr, input int nb);
      int cap;
      if (wr) return 1;
      case (bl)
         2'd0: cap = nb;
         2'd1: cap = 8;
         2'd2: cap = 4;
         default: cap = 2;
      endcase
      return (cap < nb) ? cap : nb;
   endfunction

   task automatic run_access(input logic [23:0] addr, input logic [1:0] size, input bit wr,
                             input logic [127:0] wdata, input int fw, input int bw,
                             input logic [1:0] bl, input int ew);
      int nbytes = bytes_of(size);
      int nb     = (nbytes > BB) ? nbytes / BB : 1;     // R6
      int gl     = burst_of(bl, wr, nb);                // R7
      logic [23:0] base = addr & ~(24'(nbytes - 1));    // R5
      int k = 0;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_addr       = addr;
      req_size       = size;
      req_write      = wr;
      req_wdata      = wdata;
      cfg_first_wait = 4'(fw);
      cfg_burst_wait = 2'(bw);
      cfg_burst_len  = bl;
      req_valid      = 1'b1;
      @(posedge clk);
      #1 req_valid = 1'b0;
      while (k < nb) begin
         for (int j = 0; j < gl && k < nb; j++) begin
            bit first = (j == 0);
            int len   = first ? fw + ew + 1 : bw + 1;
            for (int c = 0; c < len; c++) begin
               @(negedge clk);
               #1;
               chk(bus_cs_n == 1'b0, "R4", "cs_n low in beat", bus_cs_n, 0);
               if (wr) begin
                  chk(bus_we_n == 1'b0 && bus_rd_n == 1'b1, "R8", "write strobes",
                      {bus_we_n, bus_rd_n}, 2'b01);
                  chk(bus_dout == wdata[k*8 +: 8], "R8", "write data lane",
                      bus_dout, wdata[k*8 +: 8]);
               end else begin
                  chk(bus_rd_n == 1'b0 && bus_we_n == 1'b1, "R4", "read strobe held",
                      {bus_rd_n, bus_we_n}, 2'b01);
               end
               chk(bus_bs_n == !(first && c == 0), "R4", "bus-start strobe",
                   bus_bs_n, !(first && c == 0));
               chk(bus_addr == base + 24'(k), "R5", "beat address", bus_addr, base + 24'(k));
               // later beats: wait held high and must be ignored (R3)
               bus_wait = first ? (c < fw + ew) : 1'b1;
               @(posedge clk);
               #1;
               if (c == len - 1) begin
                  if (!wr) begin
                     chk(rsp_beat_valid == 1'b1, first ? "R2" : "R3", "beat valid at end",
                         rsp_beat_valid, 1);
                     chk(rsp_data == rom_byte(base + 24'(k)), "R2", "captured data",
                         rsp_data, rom_byte(base + 24'(k)));
                     if (j + 1 < gl && k + 1 < nb)
                        chk(bus_addr == base + 24'(k), "R5", "address not stepped at rise",
                            bus_addr, base + 24'(k));
                  end else begin
                     chk(rsp_beat_valid == 1'b0, "R8", "no beat valid on write",
                         rsp_beat_valid, 0);
                  end
                  chk(rsp_done == (k == nb - 1), "R9", "done on last beat only",
                      rsp_done, (k == nb - 1));
               end else begin
                  chk(rsp_beat_valid == 1'b0, first ? "R2" : "R3", "no early capture",
                      rsp_beat_valid, 0);
                  chk(rsp_done == 1'b0, "R9", "no early done", rsp_done, 0);
               end
            end
            k++;
         end
         @(negedge clk);
         #1;
         bus_wait = 1'b0;
         chk(bus_cs_n && bus_rd_n && bus_we_n, "R7", "one idle cycle after burst",
             {bus_cs_n, bus_rd_n, bus_we_n}, 3'b111);
         if (k == nb) begin
            chk(req_ready == 1'b0, "R9", "busy during done cycle", req_ready, 0);
            @(negedge clk);
            #1;
            chk(req_ready == 1'b1, "R9", "ready after done", req_ready, 1);
            chk(bus_cs_n == 1'b1, "R9", "cs_n still high", bus_cs_n, 1);
         end
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
   end

   initial begin
      int seed_init;
      seed_init = $urandom(32'd4711);
      repeat (3) @(negedge clk);
      #1;
      chk({bus_cs_n, bus_rd_n, bus_we_n, bus_bs_n} == 4'hF, "R1", "strobes idle in reset",
          {bus_cs_n, bus_rd_n, bus_we_n, bus_bs_n}, 4'hF);
      chk(req_ready == 1'b1, "R1", "ready in reset", req_ready, 1);
      chk(rsp_beat_valid == 1'b0 && rsp_done == 1'b0, "R1", "no response in reset",
          {rsp_beat_valid, rsp_done}, 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      chk({bus_cs_n, bus_rd_n, bus_we_n, bus_bs_n} == 4'hF, "R1", "strobes idle after reset",
          {bus_cs_n, bus_rd_n, bus_we_n, bus_bs_n}, 4'hF);

      // directed corner cases
      run_access(24'h001237, 2'd3, 1'b0, '0, 2, 1, 2'd0, 0);   // R6 unaligned 16-beat single burst
      run_access(24'h00A5F0, 2'd3, 1'b0, '0, 1, 3, 2'd1, 2);   // R7 two bursts of 8, wait on first
      run_access(24'h3FFFFE, 2'd2, 1'b0, '0, 0, 0, 2'd3, 3);   // R7 bursts of 2, zero waits
      run_access(24'h000011, 2'd0, 1'b0, '0, 15, 3, 2'd0, 1);  // R6 single normal read, max wait
      run_access(24'h123456, 2'd2, 1'b1, 128'h0000_0000_0000_0000_0000_0000_C3A5_5A7E,
                 1, 2, 2'd0, 2);                               // R8 write split into normal accesses
      run_access(24'h0F0F01, 2'd1, 1'b0, '0, 0, 0, 2'd2, 0);   // R3 2-byte burst, fastest timing
      run_access(24'h00FF00, 2'd3, 1'b0, '0, 3, 2, 2'd2, 1);   // R7 four bursts of 4

      // constrained random accesses
      for (int n = 0; n < 40; n++) begin
         logic [23:0]  a  = 24'($urandom);
         logic [1:0]   sz = 2'($urandom % 4);
         bit           w  = ($urandom % 4) == 0;
         logic [127:0] wd = {$urandom, $urandom, $urandom, $urandom};
         int           f  = $urandom % 16;
         int           b  = $urandom % 4;
         logic [1:0]   l  = 2'($urandom % 4);
         int           e  = $urandom % 4;
         run_access(a, sz, w, wd, f, b, l, e);
      end
      report();
   end

endmodule